// File: doc/BRIEF.md
# SPI Chip-Select Controller

This block owns the chip-select lines of an SPI host. Software configures it through a small 32-bit register port: it chooses which select line is the target, it sets each line's idle level, and it picks a sequencing mode. The serial engine that shifts data raises a transfer-active input for the length of each frame. The controller then drives every select line to its idle level, or to the opposite level when that line is the target and the mode calls for assertion.

Each written value is checked against the number of select lines `NUM_SEL` (1 to 8) before it is stored. An out-of-range value leaves the register as it was. In hold mode the target line stays asserted after its first frame ends. It is released only when software stores a new index or a new mode. Clock division, delay timing and data shifting are handled elsewhere.

Top module: `spi_csel_ctrl`

## Requirements
- R1: After reset the index reads 0, the mode reads 0, the polarity register reads all ones over the `NUM_SEL` implemented bits (`(1<<NUM_SEL)-1`), and every select output sits at 1.
- R2: A write to the index register (byte offset 0x00) whose 32-bit value is `NUM_SEL` or more is ignored, and the previous index is kept.
- R3: A write to the polarity register (byte offset 0x04) whose 32-bit value is `1<<NUM_SEL` or more is ignored, and the previous value is kept.
- R4: A write to the mode register (byte offset 0x08) whose 32-bit value is above 3 is ignored. Mode codes: 0 and 1 = auto, 2 = hold, 3 = off.
- R5: In auto mode the line named by the index drives the inverse of its polarity bit while the transfer-active input is high, and drives its polarity bit while it is low.
- R6: A line that is not named by the index always drives its own polarity bit, so at most one line differs from its polarity bit at any time.
- R7: In hold mode the target line is asserted during its first frame. Once a clock edge has seen the transfer-active input high, the line stays asserted after the input falls.
- R8: An accepted write to the index or the mode register releases a held line. From the clock edge that takes the write, the outputs follow the new index and mode.
- R9: In off mode no line is ever asserted. Every output equals its polarity bit, whatever the transfer-active input does.
- R10: Reads return the index, polarity and mode zero-extended at offsets 0x00, 0x04 and 0x08. Any other offset reads 0.
- R11: An accepted polarity write changes the idle level of the lines from the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| xfer_active | input | 1 | High while the serial engine is shifting a frame |
| cs_out | output | NUM_SEL | Select line levels |

## Verification
Assertions check four things on every cycle. Rejected writes to the index, polarity and mode registers leave the stored value unchanged. A stored index is always below `NUM_SEL`. At most one output departs from its polarity bit, and off mode never departs at all. The hold flag clears after an accepted index or mode write and otherwise persists while hold mode is active.

Some behaviour can only be shown by the bench's directed scenarios: the exact levels seen for given polarity and index values, the persistence of a held line across an idle gap, the release of that line by a rewrite, and the reset and readback values.

// File: rtl/spi_csel_pkg.sv
// Package: shared types and register offsets for the chip-select controller.
// Assumes byte offsets on a 32-bit register port; only the low bits decode.
package spi_csel_pkg;

    // Sequencing modes; code 1 behaves as auto.
    typedef enum logic [1:0] {
        CSM_AUTO     = 2'd0,
        CSM_AUTO_ALT = 2'd1,
        CSM_HOLD     = 2'd2,
        CSM_OFF      = 2'd3
    } csel_mode_e;

    localparam int unsigned OFF_INDEX = 0;
    localparam int unsigned OFF_POL   = 4;
    localparam int unsigned OFF_MODE  = 8;
    localparam int unsigned MODE_MAX  = 3;

endpackage

// File: rtl/spi_csel_regs.sv
// Module: register file with write validation for the chip-select controller.
// Holds the target index, the per-line polarity and the mode. A write is stored
// only when its value is in range for NUM_SEL; otherwise the register is kept.
// Assumes single-cycle write strobes; reads are combinational.
module spi_csel_regs
    import spi_csel_pkg::*;
#(
    parameter int unsigned NUM_SEL = 4,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned IDX_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic [IDX_W-1:0]   idx_q,
    output logic [NUM_SEL-1:0] pol_q,
    output csel_mode_e         mode_q,
    output logic               idx_take,
    output logic               mode_take
);

    localparam logic [31:0]        IDX_LIMIT = 32'(NUM_SEL);
    localparam logic [31:0]        POL_LIMIT = 32'd1 << NUM_SEL;
    localparam logic [NUM_SEL-1:0] POL_RESET = {NUM_SEL{1'b1}};

    logic hit_idx, hit_pol, hit_mode;
    logic pol_take;

    // Decode which register the access targets.
    always_comb begin
        hit_idx  = (32'(addr) == OFF_INDEX);
        hit_pol  = (32'(addr) == OFF_POL);
        hit_mode = (32'(addr) == OFF_MODE);
    end

    // Qualify each write by its range check.
    always_comb begin
        idx_take  = wr_en && hit_idx  && (wdata < IDX_LIMIT);
        pol_take  = wr_en && hit_pol  && (wdata < POL_LIMIT);
        mode_take = wr_en && hit_mode && (wdata <= 32'(MODE_MAX));
    end

    // Store accepted values; reset loads index 0, mode 0 and all-ones polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            pol_q  <= POL_RESET;
            mode_q <= CSM_AUTO;
        end else begin
            if (idx_take)  idx_q  <= wdata[IDX_W-1:0];
            if (pol_take)  pol_q  <= wdata[NUM_SEL-1:0];
            if (mode_take) mode_q <= csel_mode_e'(wdata[1:0]);
        end
    end

    // Return the addressed register zero-extended; unmapped offsets read 0.
    always_comb begin
        rdata = '0;
        if (hit_idx)  rdata = 32'(idx_q);
        if (hit_pol)  rdata = 32'(pol_q);
        if (hit_mode) rdata = 32'(mode_q);
    end

    p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        32'(idx_q) < IDX_LIMIT);

    p_idx_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_idx && wdata >= IDX_LIMIT) |=> $stable(idx_q));

    p_pol_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_pol && wdata >= POL_LIMIT) |=> $stable(pol_q));

    p_mode_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_mode && wdata > 32'(MODE_MAX)) |=> $stable(mode_q));

endmodule

// File: rtl/spi_csel_seq.sv
// Module: assertion sequencer. Decides whether the target line is asserted now,
// from the mode, the transfer-active input and a hold flag. The hold flag is set
// by a frame seen in hold mode and cleared by any accepted index or mode write.
// Assumes the mode can only change through an accepted mode write.
module spi_csel_seq
    import spi_csel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  csel_mode_e mode_q,
    input  logic       xfer_active,
    input  logic       idx_take,
    input  logic       mode_take,
    output logic       assert_en
);

    logic hold_q;
    logic release_req;

    // A new index or mode always releases a held line.
    always_comb release_req = idx_take || mode_take;

    // Track whether a frame has occurred since hold mode was last configured.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 hold_q <= 1'b0;
        else if (release_req)                       hold_q <= 1'b0;
        else if (mode_q == CSM_HOLD && xfer_active) hold_q <= 1'b1;
    end

    // Combine mode, frame activity and the hold flag into one assert request.
    always_comb begin
        unique case (mode_q)
            CSM_AUTO, CSM_AUTO_ALT: assert_en = xfer_active;
            CSM_HOLD:               assert_en = xfer_active || hold_q;
            default:                assert_en = 1'b0;
        endcase
    end

    p_hold_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        release_req |=> !hold_q);

    p_hold_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == CSM_HOLD && hold_q && !release_req) |=> hold_q);

endmodule

// File: rtl/spi_csel_drive.sv
// Module: per-line output drivers. The line matching the index drives the
// inverse of its polarity bit when asserted; every other line drives its bit.
// Assumes idx is already range-checked.
module spi_csel_drive
    import spi_csel_pkg::*;
#(
    parameter int unsigned NUM_SEL = 4,
    parameter int unsigned IDX_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   idx_q,
    input  logic [NUM_SEL-1:0] pol_q,
    input  csel_mode_e         mode_q,
    input  logic               assert_en,
    output logic [NUM_SEL-1:0] cs_out
);

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_line
        localparam logic [IDX_W-1:0] LINE_ID = IDX_W'(i);
        logic active;
        // Decide whether this line is the asserted target.
        always_comb active = assert_en && (idx_q == LINE_ID);
        // Drive the idle level or its inverse.
        always_comb cs_out[i] = active ? ~pol_q[i] : pol_q[i];
    end

    p_single_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_out ^ pol_q));

    p_off_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == CSM_OFF) |-> (cs_out == pol_q));

endmodule

// File: rtl/spi_csel_ctrl.sv
// Module: top of the SPI chip-select controller. Connects the validated
// register file, the assertion sequencer and the line drivers.
// Assumes 1 <= NUM_SEL <= 8 and a synchronous active-low reset.
module spi_csel_ctrl
    import spi_csel_pkg::*;
#(
    parameter int unsigned NUM_SEL = 4,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               xfer_active,
    output logic [NUM_SEL-1:0] cs_out
);

    localparam int unsigned IDX_W = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1;

    logic [IDX_W-1:0]   idx_q;
    logic [NUM_SEL-1:0] pol_q;
    csel_mode_e         mode_q;
    logic               idx_take, mode_take, assert_en;

    spi_csel_regs #(.NUM_SEL(NUM_SEL), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .idx_q(idx_q), .pol_q(pol_q),
        .mode_q(mode_q), .idx_take(idx_take), .mode_take(mode_take)
    );

    spi_csel_seq u_seq (
        .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .xfer_active(xfer_active),
        .idx_take(idx_take), .mode_take(mode_take), .assert_en(assert_en)
    );

    spi_csel_drive #(.NUM_SEL(NUM_SEL), .IDX_W(IDX_W)) u_drive (
        .clk(clk), .rst_n(rst_n), .idx_q(idx_q), .pol_q(pol_q),
        .mode_q(mode_q), .assert_en(assert_en), .cs_out(cs_out)
    );

endmodule

// File: tb/spi_csel_ctrl_test.sv
// Directed bench for the chip-select controller, NUM_SEL = 4.
module spi_csel_ctrl_test;

    localparam int unsigned N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [7:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         xfer_active = 1'b0;
    logic [N-1:0] cs_out;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    spi_csel_ctrl #(.NUM_SEL(N), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .xfer_active(xfer_active), .cs_out(cs_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Write on one edge; return at the following falling edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = '0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
        reg_addr = 8'h00;
    endtask

    task automatic set_xfer(input logic v);
        @(negedge clk);
        xfer_active = v;
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset;
        #1;
        rd_check("R1 index", 8'h00, 32'd0);
        rd_check("R1 mode", 8'h08, 32'd0);
        rd_check("R1 polarity", 8'h04, 32'hF);
        check("R1 outputs", 32'(cs_out), 32'hF);
        rd_check("R10 unmapped", 8'h0C, 32'd0);
    endtask

    task automatic t_index_range;
        wr(8'h00, 32'd3);
        rd_check("R2 accept", 8'h00, 32'd3);
        wr(8'h00, 32'd4);
        rd_check("R2 reject 4", 8'h00, 32'd3);
        wr(8'h00, 32'hFFFF_FFFF);
        rd_check("R2 reject max", 8'h00, 32'd3);
    endtask

    task automatic t_pol_range;
        wr(8'h04, 32'h5);
        rd_check("R3 accept", 8'h04, 32'h5);
        #1 check("R11 idle level", 32'(cs_out), 32'h5);
        wr(8'h04, 32'h10);
        rd_check("R3 reject", 8'h04, 32'h5);
        check("R3 outputs kept", 32'(cs_out), 32'h5);
        wr(8'h04, 32'hF);
    endtask

    task automatic t_mode_range;
        wr(8'h08, 32'd2);
        rd_check("R4 accept", 8'h08, 32'd2);
        wr(8'h08, 32'd4);
        rd_check("R4 reject", 8'h08, 32'd2);
        wr(8'h08, 32'd0);
        rd_check("R10 mode readback", 8'h08, 32'd0);
    endtask

    task automatic t_auto;
        wr(8'h04, 32'hF);
        wr(8'h00, 32'd1);
        wr(8'h08, 32'd0);
        set_xfer(1'b1);
        check("R5 auto active", 32'(cs_out), 32'hD);
        set_xfer(1'b0);
        check("R5 auto idle", 32'(cs_out), 32'hF);
        wr(8'h08, 32'd1);
        set_xfer(1'b1);
        check("R5 auto code1", 32'(cs_out), 32'hD);
        set_xfer(1'b0);
        wr(8'h04, 32'h5);
        wr(8'h00, 32'd0);
        check("R11 new idle", 32'(cs_out), 32'h5);
        set_xfer(1'b1);
        check("R6 others at polarity", 32'(cs_out), 32'h4);
        set_xfer(1'b0);
        check("R5 idle low-pol", 32'(cs_out), 32'h5);
        wr(8'h04, 32'hF);
    endtask

    task automatic t_hold;
        wr(8'h00, 32'd2);
        wr(8'h08, 32'd2);
        #1 check("R7 before frame", 32'(cs_out), 32'hF);
        set_xfer(1'b1);
        check("R7 in frame", 32'(cs_out), 32'hB);
        set_xfer(1'b0);
        check("R7 held after frame", 32'(cs_out), 32'hB);
        repeat (3) @(negedge clk);
        #1 check("R7 still held", 32'(cs_out), 32'hB);
        wr(8'h00, 32'd0);
        #1 check("R8 index release", 32'(cs_out), 32'hF);
        set_xfer(1'b1);
        set_xfer(1'b0);
        check("R7 held line0", 32'(cs_out), 32'hE);
        wr(8'h08, 32'd2);
        #1 check("R8 mode rewrite release", 32'(cs_out), 32'hF);
        set_xfer(1'b1);
        set_xfer(1'b0);
        wr(8'h00, 32'd7);
        #1 check("R2 rejected index keeps hold", 32'(cs_out), 32'hE);
        wr(8'h08, 32'd0);
        #1 check("R8 mode change release", 32'(cs_out), 32'hF);
    endtask

    task automatic t_off;
        wr(8'h08, 32'd3);
        set_xfer(1'b1);
        check("R9 off pol F", 32'(cs_out), 32'hF);
        wr(8'h04, 32'h5);
        #1 check("R9 off pol 5", 32'(cs_out), 32'h5);
        set_xfer(1'b0);
        check("R9 off idle", 32'(cs_out), 32'h5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_index_range();
        t_pol_range();
        t_mode_range();
        t_auto();
        t_hold();
        t_off();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule